// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake Qualification

This block sits next to a processor core and moves it between normal running and three graded sleep states. Software first sets a two-bit sleep-depth field. The sleep is entered only when the core signals that it has executed its idle instruction. Each depth stops a different set of clocks through registered enable outputs. The light state keeps every clock running. The middle state gates the CPU clock but leaves the oscillator up. The deep state also shuts the oscillator and PLL down.

Each sleep state accepts its own set of wake sources. These include interrupts, the watchdog, a debugger request, and one active-low GPIO line chosen from a group by a select input. The GPIO line counts as a wake only after it has stayed low for a programmed number of oscillator cycles. On leaving the deep state, the sequencer first restarts the oscillator. It then waits for a stable indication before it qualifies the line and releases the CPU clock. Every wake from the two gated states sends a one-cycle wake-interrupt request to the interrupt controller. A companion flag tells the core whether to service that interrupt or to resume after the idle instruction.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, and whenever reset is applied in any state, the block is in run state (lpm_state 0) with cpu_clk_en=1, osc_en=1 and wake_irq=0.
- R2: The depth field is decoded only in a cycle where idle_exec=1 in run state: 00 enters idle (lpm_state 1), 01 enters standby (2), and 10 or 11 enters halt (3). The new state shows one clock later. Changing mode_sel without idle_exec has no effect.
- R3: In idle, cpu_clk_en and osc_en stay 1. Idle returns to run on the clock after wd_irq=1 or irq_pending=1, with no wake_irq pulse.
- R4: In standby, cpu_clk_en=0 and osc_en=1. irq_pending has no effect there. wd_irq wakes only while wd_wake_en=1.
- R5: The line gpio_in[gpio_sel] qualifies as a wake after qual_len+2 consecutive low samples taken while qualification is active. A high sample restarts the count. Lines that are not selected have no effect.
- R6: A wake from standby (qualified line, enabled watchdog, or dbg_req) gives run state on the next clock with cpu_clk_en=1. wake_irq is high for exactly that one cycle.
- R7: In halt, cpu_clk_en=0 and osc_en=0, and wd_irq and irq_pending are ignored. A low on the selected line (unqualified) or dbg_req moves the block to warm-up (lpm_state 4), where osc_en=1 and cpu_clk_en=0.
- R8: In warm-up, no qualification happens while osc_stable=0. Once osc_stable=1, dbg_req or a qualified line gives run state with a wake_irq pulse. A high line with no dbg_req returns the block to halt.
- R9: While wake_irq=1, wake_isr=1 for a wake from standby. For a wake from warm-up, wake_isr equals the inverse of int_mask.
- R10: Both clock enables come straight from registers and change only in the cycle that the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset (also a wake source) |
| mode_sel | input | 2 | Sleep-depth field |
| idle_exec | input | 1 | Core has executed its idle instruction |
| wd_wake_en | input | 1 | Allow watchdog wake from standby |
| qual_len | input | QUAL_W | Qualification length; window is qual_len+2 cycles |
| gpio_sel | input | SEL_W | Index of the GPIO wake line |
| gpio_in | input | N_GPIO | Port GPIO lines, wake is active low |
| wd_irq | input | 1 | Watchdog interrupt |
| irq_pending | input | 1 | Any enabled interrupt or NMI |
| dbg_req | input | 1 | Debugger wake request |
| osc_stable | input | 1 | Oscillator and PLL report stable |
| int_mask | input | 1 | Core global interrupt mask |
| lpm_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator and PLL enable |
| wake_irq | output | 1 | One-cycle wake-interrupt request |
| wake_isr | output | 1 | With wake_irq: service the wake interrupt (1) or resume after idle (0) |

## Verification
The qualifier is tested with an unbroken low run exactly as long as the window. This shows whether the window is qual_len+2 cycles or off by one. It is also tested with a run broken by one high sample, which shows a real restart apart from a pause in the count. A low on a line that is not selected checks the selector. Every wake source is applied in each sleep state, including sources that must be ignored. The deep-state exit is tried with the stable input held low and with the mask both set and clear, which separates the warm-up gating and the service-or-resume flag.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_STBY = 3'd2,
    ST_HALT = 3'd3,
    ST_WARM = 3'd4
  } lpm_state_e;

  // Sleep state chosen by the depth field at idle time.
  function automatic lpm_state_e depth_to_state(input logic [1:0] depth);
    if (depth[1])      return ST_HALT;
    else if (depth[0]) return ST_STBY;
    else               return ST_IDLE;
  endfunction

  // Number of consecutive low samples needed for a qualified wake.
  function automatic int unsigned qual_window(input int unsigned len);
    return len + 2;
  endfunction
endpackage

// File: rtl/lpm_wake_select.sv
module lpm_wake_select #(
  parameter int N_GPIO = 32,
  localparam int SEL_W = (N_GPIO > 1) ? $clog2(N_GPIO) : 1
) (
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic [SEL_W-1:0]  gpio_sel,
  output logic              sel_low
);
  logic [N_GPIO-1:0] hit;
  for (genvar g = 0; g < N_GPIO; g++) begin : g_line
    assign hit[g] = (gpio_sel == SEL_W'(g)) && !gpio_in[g];
  end
  assign sel_low = |hit;
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int QUAL_W = 6,
  localparam int CNT_W = QUAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_low,
  input  logic [QUAL_W-1:0] qual_len,
  output logic              qual_done
);
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx  = CNT_W'(qual_window(int'(qual_len)) - 1);
  assign qual_done = enable && line_low && (low_cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt <= '0;
    else if (!enable || !line_low)      low_cnt <= '0;
    else if (low_cnt != last_idx)       low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_wake_sources.sv
module lpm_wake_sources
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       wd_irq,
  input  logic       wd_wake_en,
  input  logic       irq_pending,
  input  logic       dbg_req,
  input  logic       sel_low,
  input  logic       qual_done,
  input  logic       osc_stable,
  output logic       idle_exit,
  output logic       stby_exit,
  output logic       halt_arm,
  output logic       warm_exit,
  output logic       warm_abort
);
  assign idle_exit  = (state == ST_IDLE) && (wd_irq || irq_pending);
  assign stby_exit  = (state == ST_STBY) && ((wd_irq && wd_wake_en) || qual_done || dbg_req);
  assign halt_arm   = (state == ST_HALT) && (sel_low || dbg_req);
  assign warm_exit  = (state == ST_WARM) && osc_stable && (dbg_req || qual_done);
  assign warm_abort = (state == ST_WARM) && osc_stable && !dbg_req && !sel_low;
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int N_GPIO = 32,
  parameter int QUAL_W = 6,
  localparam int SEL_W = (N_GPIO > 1) ? $clog2(N_GPIO) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              idle_exec,
  input  logic              wd_wake_en,
  input  logic [QUAL_W-1:0] qual_len,
  input  logic [SEL_W-1:0]  gpio_sel,
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic              wd_irq,
  input  logic              irq_pending,
  input  logic              dbg_req,
  input  logic              osc_stable,
  input  logic              int_mask,
  output logic [2:0]        lpm_state,
  output logic              cpu_clk_en,
  output logic              osc_en,
  output logic              wake_irq,
  output logic              wake_isr
);
  lpm_state_e state_q, state_d;
  logic sel_low, qual_done, qual_en;
  logic idle_exit, stby_exit, halt_arm, warm_exit, warm_abort;
  logic wake_evt;

  lpm_wake_select #(.N_GPIO(N_GPIO)) u_sel (
    .gpio_in(gpio_in), .gpio_sel(gpio_sel), .sel_low(sel_low)
  );

  assign qual_en = (state_q == ST_STBY) || ((state_q == ST_WARM) && osc_stable);

  lpm_wake_qual #(.QUAL_W(QUAL_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .enable(qual_en), .line_low(sel_low),
    .qual_len(qual_len), .qual_done(qual_done)
  );

  lpm_wake_sources u_src (
    .state(state_q), .wd_irq(wd_irq), .wd_wake_en(wd_wake_en),
    .irq_pending(irq_pending), .dbg_req(dbg_req), .sel_low(sel_low),
    .qual_done(qual_done), .osc_stable(osc_stable),
    .idle_exit(idle_exit), .stby_exit(stby_exit), .halt_arm(halt_arm),
    .warm_exit(warm_exit), .warm_abort(warm_abort)
  );

  assign wake_evt = stby_exit || warm_exit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (idle_exec) state_d = depth_to_state(mode_sel);
      ST_IDLE: if (idle_exit) state_d = ST_RUN;
      ST_STBY: if (stby_exit) state_d = ST_RUN;
      ST_HALT: if (halt_arm)  state_d = ST_WARM;
      ST_WARM: begin
        if (warm_exit)       state_d = ST_RUN;
        else if (warm_abort) state_d = ST_HALT;
      end
      default: state_d = ST_RUN;
    endcase
  end

  // Clock enables are decoded from the next state and registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cpu_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      wake_irq   <= 1'b0;
      wake_isr   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cpu_clk_en <= (state_d == ST_RUN) || (state_d == ST_IDLE);
      osc_en     <= (state_d != ST_HALT);
      wake_irq   <= wake_evt;
      wake_isr   <= stby_exit || (warm_exit && !int_mask);
    end
  end

  assign lpm_state = state_q;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_exec,
  input logic       osc_stable,
  input logic [2:0] lpm_state,
  input logic       cpu_clk_en,
  input logic       osc_en,
  input logic       wake_irq,
  input logic       sel_low,
  input logic       qual_done
);
  a_r2_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_state == 3'd0 && !idle_exec) |=> lpm_state == 3'd0);
  a_r3_idle_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_state == 3'd1) |-> (cpu_clk_en && osc_en));
  a_r4_stby_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_state == 3'd2) |-> (!cpu_clk_en && osc_en));
  a_r5_done_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    qual_done |-> sel_low);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  a_r6_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (lpm_state == 3'd0 && cpu_clk_en));
  a_r7_halt_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_state == 3'd3) |-> (!cpu_clk_en && !osc_en));
  a_r8_warm_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_state == 3'd4 && !osc_stable) |=> lpm_state == 3'd4);
  a_r10_cpu_en_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lpm_state) |-> $stable(cpu_clk_en));
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (.*);

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
  localparam int N_GPIO = 32;
  localparam int QUAL_W = 6;
  localparam int SEL_W  = $clog2(N_GPIO);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic idle_exec = 1'b0, wd_wake_en = 1'b0, wd_irq = 1'b0, irq_pending = 1'b0;
  logic dbg_req = 1'b0, osc_stable = 1'b0, int_mask = 1'b0;
  logic [QUAL_W-1:0] qual_len = 6'd3;
  logic [SEL_W-1:0] gpio_sel = 5'd5;
  logic [N_GPIO-1:0] gpio_in = '1;
  logic [2:0] lpm_state;
  logic cpu_clk_en, osc_en, wake_irq, wake_isr;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic exp_q[$];
  logic prev_wake = 1'b0;

  always #5 clk = ~clk;

  lpm_sequencer #(.N_GPIO(N_GPIO), .QUAL_W(QUAL_W)) dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] m);
    mode_sel = m; idle_exec = 1'b1; tick(1); idle_exec = 1'b0;
  endtask

  // Monitor: each wake pulse pops one expected service flag.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake_irq) begin
        if (prev_wake) chk("R6 pulse width", 8'd2, 8'd1);
        if (exp_q.size() == 0) chk("R6 unexpected wake", 8'd1, 8'd0);
        else chk("R9 wake_isr", {7'd0, wake_isr}, {7'd0, exp_q.pop_front()});
      end
      prev_wake = wake_irq;
    end
  end

  initial begin
    tick(2); rst_n = 1'b1; tick(1);
    chk("R1 state", {5'd0, lpm_state}, 8'd0);
    chk("R1 cpu_clk_en", {7'd0, cpu_clk_en}, 8'd1);
    chk("R1 osc_en", {7'd0, osc_en}, 8'd1);
    chk("R1 wake_irq", {7'd0, wake_irq}, 8'd0);

    mode_sel = 2'b10; tick(3);
    chk("R2 no idle_exec", {5'd0, lpm_state}, 8'd0);

    enter(2'b00);
    chk("R2 idle entry", {5'd0, lpm_state}, 8'd1);
    chk("R3 idle cpu clk", {7'd0, cpu_clk_en}, 8'd1);
    dbg_req = 1'b1; tick(2); dbg_req = 1'b0;
    chk("R3 dbg ignored in idle", {5'd0, lpm_state}, 8'd1);
    irq_pending = 1'b1; tick(1); irq_pending = 1'b0;
    chk("R3 irq exits idle", {5'd0, lpm_state}, 8'd0);

    enter(2'b01);
    chk("R2 standby entry", {5'd0, lpm_state}, 8'd2);
    chk("R4 stby cpu clk", {7'd0, cpu_clk_en}, 8'd0);
    chk("R4 stby osc", {7'd0, osc_en}, 8'd1);
    irq_pending = 1'b1; wd_irq = 1'b1; tick(2); irq_pending = 1'b0;
    chk("R4 ignored sources", {5'd0, lpm_state}, 8'd2);
    exp_q.push_back(1'b1);
    wd_wake_en = 1'b1; tick(1); wd_irq = 1'b0; wd_wake_en = 1'b0;
    chk("R6 wd wake", {5'd0, lpm_state}, 8'd0);
    chk("R6 cpu clk back", {7'd0, cpu_clk_en}, 8'd1);

    // qualification, window 5
    enter(2'b01);
    gpio_in[2] = 1'b0; tick(10); gpio_in[2] = 1'b1;
    chk("R5 unselected line", {5'd0, lpm_state}, 8'd2);
    exp_q.push_back(1'b1);
    gpio_in[5] = 1'b0; tick(4);
    chk("R5 window not yet", {5'd0, lpm_state}, 8'd2);
    tick(1);
    chk("R5 window reached", {5'd0, lpm_state}, 8'd0);
    gpio_in[5] = 1'b1; tick(1);

    enter(2'b01);
    gpio_in[5] = 1'b0; tick(4); gpio_in[5] = 1'b1; tick(1);
    exp_q.push_back(1'b1);
    gpio_in[5] = 1'b0; tick(4);
    chk("R5 restart after high", {5'd0, lpm_state}, 8'd2);
    tick(1);
    chk("R5 restart full window", {5'd0, lpm_state}, 8'd0);
    gpio_in[5] = 1'b1; tick(1);

    qual_len = 6'd0;
    enter(2'b01);
    exp_q.push_back(1'b1);
    gpio_in[5] = 1'b0; tick(1);
    chk("R5 min window not yet", {5'd0, lpm_state}, 8'd2);
    tick(1);
    chk("R5 min window", {5'd0, lpm_state}, 8'd0);
    gpio_in[5] = 1'b1; qual_len = 6'd3; tick(1);

    enter(2'b01);
    exp_q.push_back(1'b1);
    dbg_req = 1'b1; tick(1); dbg_req = 1'b0;
    chk("R6 dbg wake", {5'd0, lpm_state}, 8'd0);
    tick(1);

    // halt, masked exit through qualification
    osc_stable = 1'b0; int_mask = 1'b1;
    enter(2'b11);
    chk("R2 halt entry", {5'd0, lpm_state}, 8'd3);
    chk("R7 halt osc", {7'd0, osc_en}, 8'd0);
    chk("R7 halt cpu", {7'd0, cpu_clk_en}, 8'd0);
    wd_irq = 1'b1; irq_pending = 1'b1; tick(2); wd_irq = 1'b0; irq_pending = 1'b0;
    chk("R7 halt ignores irq", {5'd0, lpm_state}, 8'd3);
    gpio_in[5] = 1'b0; tick(1);
    chk("R7 warm entry", {5'd0, lpm_state}, 8'd4);
    chk("R7 warm osc", {7'd0, osc_en}, 8'd1);
    chk("R7 warm cpu", {7'd0, cpu_clk_en}, 8'd0);
    tick(8);
    chk("R8 waits for stable", {5'd0, lpm_state}, 8'd4);
    exp_q.push_back(1'b0);
    osc_stable = 1'b1; tick(4);
    chk("R8 qualifying", {5'd0, lpm_state}, 8'd4);
    tick(1);
    chk("R8 qualified exit", {5'd0, lpm_state}, 8'd0);
    gpio_in[5] = 1'b1; tick(1);

    // halt, debugger exit, mask clear
    osc_stable = 1'b0; int_mask = 1'b0;
    enter(2'b10);
    dbg_req = 1'b1; tick(1);
    chk("R7 dbg arms warm", {5'd0, lpm_state}, 8'd4);
    tick(2);
    exp_q.push_back(1'b1);
    osc_stable = 1'b1; tick(1); dbg_req = 1'b0;
    chk("R8 dbg exit", {5'd0, lpm_state}, 8'd0);
    tick(1);

    // halt, glitch returns to halt
    osc_stable = 1'b0;
    enter(2'b11);
    gpio_in[5] = 1'b0; tick(1);
    chk("R7 glitch arms", {5'd0, lpm_state}, 8'd4);
    gpio_in[5] = 1'b1; osc_stable = 1'b1; tick(1);
    chk("R8 back to halt", {5'd0, lpm_state}, 8'd3);
    chk("R8 osc off again", {7'd0, osc_en}, 8'd0);

    rst_n = 1'b0; tick(1);
    chk("R1 reset from halt", {5'd0, lpm_state}, 8'd0);
    chk("R1 reset osc", {7'd0, osc_en}, 8'd1);
    rst_n = 1'b1; tick(2);

    chk("R6 all wakes seen", exp_q.size()[7:0], 8'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule